// File: doc/BRIEF.md
# Sixteen-Bit Compare Timer with Atomic Byte Access

This block is a 16-bit up-counter with two output-compare channels, A and B. A CPU reaches it over an 8-bit register bus. The counter and both compare values are 16 bits wide. Each one shows up as a pair of byte addresses, one for the low byte and one for the high byte. A single 8-bit holding byte is shared by all three 16-bit values. Because of it, a two-byte access always moves a coherent 16-bit value, even while the counter is running.

The counter advances once per cycle in which `tick` is high. Each channel compares its value with the counter on every tick. A match sets that channel's sticky flag, can raise its interrupt request and can toggle its waveform output. The counter either wraps freely and reports overflow, or it restarts from zero after reaching compare A. Software can force a channel's waveform action without any match. A counter write masks the compare logic for the next tick, so that loading the counter cannot produce a spurious match.

Top module: `tmr16_atomic`

## Requirements
- R1: After reset every register address reads 0x00 and all five outputs are low.
- R2: A write to a high-byte address (1 counter, 3 compare A, 5 compare B) only loads the shared holding byte, and the target keeps its old value. A write to a low-byte address (0, 2, 4) stores {holding byte, written byte} into that target in one cycle, and the holding byte may have been loaded through any high-byte address.
- R3: A read of a low-byte address returns the live low byte and copies that register's high byte into the holding byte. A read of any high-byte address returns the holding byte, not the live high byte.
- R4: Each cycle with `tick` high and no counter write adds one to the counter. With control bit 0 clear, the step from 0xFFFF goes to 0x0000 and sets the overflow flag (flag bit 2).
- R5: With control bit 0 set, a tick taken while the counter equals compare A loads 0x0000 instead of the increment, and sets no overflow flag. This also happens on a tick whose match is suppressed by R7.
- R6: A tick on which the counter equals a channel's compare value sets that channel's flag (bit 0 for A, bit 1 for B) at address 8.
- R7: A counter write takes priority over a tick in the same cycle. The first tick after a counter write increments but raises no match on either channel.
- R8: When a channel's toggle enable is set (control bit 4 for A, bit 5 for B), its waveform output inverts on each match.
- R9: A write to address 8'h7 with bit 0 (A) or bit 1 (B) set inverts that channel's waveform output when its toggle enable is set. It sets no flag, raises no interrupt and leaves the counter unchanged. Address 7 reads 0x00.
- R10: Writing 1 to a flag bit at address 8 clears it. A match or overflow in the same cycle wins over the clear.
- R11: Each interrupt output is its flag ANDed with its enable: control bit 1 for A, bit 2 for B, bit 3 for overflow. Control bits 7:6 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer step enable |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives holding-byte capture) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| irq_cmp_a | output | 1 | Channel A interrupt request |
| irq_cmp_b | output | 1 | Channel B interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |
| wave_a | output | 1 | Channel A waveform output |
| wave_b | output | 1 | Channel B waveform output |

## Verification
The assertions check on every cycle that:
- each tick steps the counter by one, or clears it on compare A in clear mode;
- a counter load blocks matches on the following tick;
- a flag rises only from a match, and a match always leaves its flag set;
- a waveform edge always follows a match or a force strobe.

Only the bench's scenarios can show the following, because they depend on bus sequences:
- the holding byte shared across registers;
- the stale high byte after a low read;
- set-over-clear in one cycle;
- force strobes that touch neither flags nor counter.

A behavioural model compares the read data, interrupts and waveforms on every clock, including across a full counter wrap.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int ADDR_W = 4;
  localparam int NCH    = 2;
  localparam int NFLG   = NCH + 1;

  typedef enum logic [ADDR_W-1:0] {
    RA_CNT_LO  = 4'd0,
    RA_CNT_HI  = 4'd1,
    RA_CMPA_LO = 4'd2,
    RA_CMPA_HI = 4'd3,
    RA_CMPB_LO = 4'd4,
    RA_CMPB_HI = 4'd5,
    RA_CTRL    = 4'd6,
    RA_FORCE   = 4'd7,
    RA_FLAGS   = 4'd8
  } reg_addr_e;

  // control byte, bits 5:0; bits 7:6 are not stored
  typedef struct packed {
    logic [NCH-1:0] tog_en;    // bits 5:4
    logic           ie_ovf;    // bit 3
    logic [NCH-1:0] ie_cmp;    // bits 2:1
    logic           clr_on_a;  // bit 0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  function automatic logic [BYTE_W-1:0] f_lo(input logic [CNT_W-1:0] v);
    return v[BYTE_W-1:0];
  endfunction

  function automatic logic [BYTE_W-1:0] f_hi(input logic [CNT_W-1:0] v);
    return v[CNT_W-1:BYTE_W];
  endfunction

  function automatic logic f_match(input logic [CNT_W-1:0] cnt, input logic [CNT_W-1:0] cmp);
    return cnt == cmp;
  endfunction

  function automatic logic [CNT_W-1:0] f_next_cnt(input logic [CNT_W-1:0] cnt,
                                                   input logic [CNT_W-1:0] top,
                                                   input logic clr_on_a);
    if (clr_on_a && (cnt == top)) return '0;
    return cnt + 1'b1;
  endfunction

  function automatic logic f_wrap(input logic [CNT_W-1:0] cnt, input logic clr_on_a);
    return !clr_on_a && (cnt == {CNT_W{1'b1}});
  endfunction
endpackage

// File: rtl/tmr16_bus.sv
module tmr16_bus
  import tmr16_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic                       rd,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [BYTE_W-1:0]          wdata,
  input  logic [CNT_W-1:0]           cnt,
  input  logic [NFLG-1:0]            flags,
  output logic [BYTE_W-1:0]          rdata,
  output logic                       cnt_wr,
  output logic [CNT_W-1:0]           cnt_wdata,
  output logic [NCH-1:0][CNT_W-1:0]  cmp,
  output ctrl_t                      ctrl,
  output logic [NCH-1:0]             frc,
  output logic [NFLG-1:0]            flg_clr
);
  logic [BYTE_W-1:0] hold_q;
  logic              hi_wr;
  logic              lo_rd;
  logic [BYTE_W-1:0] lo_rd_hi;
  logic [NCH-1:0]    cmp_wr;

  always_comb begin
    hi_wr     = wr && (addr == RA_CNT_HI || addr == RA_CMPA_HI || addr == RA_CMPB_HI);
    cnt_wr    = wr && (addr == RA_CNT_LO);
    cnt_wdata = {hold_q, wdata};
    frc       = (wr && addr == RA_FORCE) ? wdata[NCH-1:0]  : '0;
    flg_clr   = (wr && addr == RA_FLAGS) ? wdata[NFLG-1:0] : '0;
    for (int ch = 0; ch < NCH; ch++)
      cmp_wr[ch] = wr && (addr == ADDR_W'(int'(RA_CMPA_LO) + 2 * ch));
  end

  // read mux and holding-byte capture source
  always_comb begin
    rdata    = '0;
    lo_rd    = 1'b0;
    lo_rd_hi = '0;
    case (reg_addr_e'(addr))
      RA_CNT_LO: begin
        rdata    = f_lo(cnt);
        lo_rd    = rd;
        lo_rd_hi = f_hi(cnt);
      end
      RA_CMPA_LO: begin
        rdata    = f_lo(cmp[0]);
        lo_rd    = rd;
        lo_rd_hi = f_hi(cmp[0]);
      end
      RA_CMPB_LO: begin
        rdata    = f_lo(cmp[1]);
        lo_rd    = rd;
        lo_rd_hi = f_hi(cmp[1]);
      end
      RA_CNT_HI, RA_CMPA_HI, RA_CMPB_HI: rdata = hold_q;
      RA_CTRL:  rdata = BYTE_W'(ctrl);
      RA_FLAGS: rdata = BYTE_W'(flags);
      default:  rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      ctrl   <= '0;
      cmp    <= '0;
    end else begin
      if (hi_wr)      hold_q <= wdata;
      else if (lo_rd) hold_q <= lo_rd_hi;
      if (wr && addr == RA_CTRL) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
      for (int ch = 0; ch < NCH; ch++)
        if (cmp_wr[ch]) cmp[ch] <= {hold_q, wdata};
    end
  end
endmodule

// File: rtl/tmr16_count.sv
module tmr16_count
  import tmr16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] top,
  input  logic             clr_on_a,
  output logic [CNT_W-1:0] cnt,
  output logic             eval,
  output logic             blk,
  output logic             wrap
);
  assign eval = tick && !ld;
  assign wrap = eval && f_wrap(cnt, clr_on_a);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      blk <= 1'b0;
    end else if (ld) begin
      cnt <= ld_val;
      blk <= 1'b1;
    end else if (tick) begin
      cnt <= f_next_cnt(cnt, top, clr_on_a);
      blk <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr16_chan.sv
module tmr16_chan
  import tmr16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             eval,
  input  logic             blk,
  input  logic             frc,
  input  logic             tog_en,
  input  logic             clr,
  output logic             evt,
  output logic             flag,
  output logic             wave
);
  assign evt = eval && !blk && f_match(cnt, cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      wave <= 1'b0;
    end else begin
      if (evt)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
      if (tog_en && (evt || frc)) wave <= !wave;
    end
  end
endmodule

// File: rtl/tmr16_atomic.sv
module tmr16_atomic
  import tmr16_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BYTE_W-1:0]   bus_wdata,
  output logic [BYTE_W-1:0]   bus_rdata,
  output logic                irq_cmp_a,
  output logic                irq_cmp_b,
  output logic                irq_ovf,
  output logic                wave_a,
  output logic                wave_b
);
  logic [CNT_W-1:0]          cnt_q;
  logic                      ld_s;
  logic [CNT_W-1:0]          ld_val_s;
  logic [NCH-1:0][CNT_W-1:0] cmp_s;
  ctrl_t                     ctrl_s;
  logic [NCH-1:0]            frc_s;
  logic [NFLG-1:0]           clr_s;
  logic                      eval_s;
  logic                      blk_s;
  logic                      wrap_s;
  logic [NCH-1:0]            evt_s;
  logic [NCH-1:0]            flag_s;
  logic [NCH-1:0]            wave_s;
  logic                      ovf_q;
  logic [NFLG-1:0]           flags_s;
  logic                      clr_mode_s;
  logic [CNT_W-1:0]          top_a_s;

  assign flags_s    = {ovf_q, flag_s};
  assign clr_mode_s = ctrl_s.clr_on_a;
  assign top_a_s    = cmp_s[0];

  tmr16_bus u_bus (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .cnt(cnt_q), .flags(flags_s), .rdata(bus_rdata),
    .cnt_wr(ld_s), .cnt_wdata(ld_val_s), .cmp(cmp_s), .ctrl(ctrl_s),
    .frc(frc_s), .flg_clr(clr_s)
  );

  tmr16_count u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ld(ld_s), .ld_val(ld_val_s),
    .top(top_a_s), .clr_on_a(clr_mode_s), .cnt(cnt_q), .eval(eval_s),
    .blk(blk_s), .wrap(wrap_s)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    tmr16_chan u_chan (
      .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .cmp(cmp_s[ch]), .eval(eval_s),
      .blk(blk_s), .frc(frc_s[ch]), .tog_en(ctrl_s.tog_en[ch]), .clr(clr_s[ch]),
      .evt(evt_s[ch]), .flag(flag_s[ch]), .wave(wave_s[ch])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ovf_q <= 1'b0;
    else if (wrap_s)     ovf_q <= 1'b1;
    else if (clr_s[NCH]) ovf_q <= 1'b0;
  end

  assign irq_cmp_a = flag_s[0] && ctrl_s.ie_cmp[0];
  assign irq_cmp_b = flag_s[1] && ctrl_s.ie_cmp[1];
  assign irq_ovf   = ovf_q && ctrl_s.ie_ovf;
  assign wave_a    = wave_s[0];
  assign wave_b    = wave_s[1];
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk
  import tmr16_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] top_a,
  input logic             clr_mode,
  input logic             eval,
  input logic             blk,
  input logic             cnt_wr,
  input logic             evt_a,
  input logic             evt_b,
  input logic             frc_a,
  input logic             frc_b,
  input logic             flag_a,
  input logic             flag_b,
  input logic             wave_a,
  input logic             wave_b
);
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !clr_mode) |=> cnt == CNT_W'($past(cnt) + 1'b1));

  a_r5_clear_on_a: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && clr_mode && cnt == top_a) |=> cnt == '0);

  a_r7_load_masks: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> blk);

  a_r7_no_match_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> !(evt_a || evt_b));

  a_r6_flag_a_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_a) |-> $past(evt_a));

  a_r6_flag_b_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_b) |-> $past(evt_b));

  a_r10_set_wins_a: assert property (@(posedge clk) disable iff (!rst_n)
    evt_a |=> flag_a);

  a_r10_set_wins_b: assert property (@(posedge clk) disable iff (!rst_n)
    evt_b |=> flag_b);

  a_r8_wave_a_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wave_a) |-> $past(evt_a || frc_a));

  a_r9_wave_b_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wave_b) |-> $past(evt_b || frc_b));
endmodule

bind tmr16_atomic tmr16_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .top_a(top_a_s), .clr_mode(clr_mode_s),
  .eval(eval_s), .blk(blk_s), .cnt_wr(ld_s), .evt_a(evt_s[0]), .evt_b(evt_s[1]),
  .frc_a(frc_s[0]), .frc_b(frc_s[1]), .flag_a(flag_s[0]), .flag_b(flag_s[1]),
  .wave_a(wave_s[0]), .wave_b(wave_s[1])
);

// File: tb/tmr16_atomic_bench.sv
module tmr16_atomic_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_a, irq_b, irq_o, wv_a, wv_b;

  int n_chk = 0;
  int n_bad = 0;

  // behavioural reference state
  int m_cnt, m_cmpa, m_cmpb, m_hold, m_ctrl, m_flags, m_wa, m_wb, m_blk;

  always #10 clk = ~clk;

  tmr16_atomic u_tmr16_atomic (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(wr), .bus_rd(rd),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .irq_cmp_a(irq_a), .irq_cmp_b(irq_b), .irq_ovf(irq_o),
    .wave_a(wv_a), .wave_b(wv_b)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int model_rd(input int a);
    case (a)
      0:       return m_cnt % 256;
      1, 3, 5: return m_hold;
      2:       return m_cmpa % 256;
      4:       return m_cmpb % 256;
      6:       return m_ctrl;
      8:       return m_flags;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int ld, ev, ma, mb, wp, frc, clr, ncnt, nhold, clrmode;
    if (!rst_n) begin
      m_cnt = 0; m_cmpa = 0; m_cmpb = 0; m_hold = 0; m_ctrl = 0;
      m_flags = 0; m_wa = 0; m_wb = 0; m_blk = 0;
    end else begin
      clrmode = m_ctrl % 2;
      ld  = (wr && addr == 0) ? 1 : 0;
      ev  = (tick && !ld) ? 1 : 0;
      ma  = (ev && !m_blk && m_cnt == m_cmpa) ? 1 : 0;
      mb  = (ev && !m_blk && m_cnt == m_cmpb) ? 1 : 0;
      wp  = (ev && !clrmode && m_cnt == 65535) ? 1 : 0;
      frc = (wr && addr == 7) ? wdata % 4 : 0;
      clr = (wr && addr == 8) ? wdata % 8 : 0;
      ncnt = m_cnt;
      if (ld) begin
        ncnt = m_hold * 256 + wdata;
        m_blk = 1;
      end else if (tick) begin
        ncnt = (clrmode && m_cnt == m_cmpa) ? 0 : (m_cnt + 1) % 65536;
        m_blk = 0;
      end
      nhold = m_hold;
      if (wr && (addr == 1 || addr == 3 || addr == 5)) nhold = wdata;
      else if (rd && addr == 0) nhold = m_cnt / 256;
      else if (rd && addr == 2) nhold = m_cmpa / 256;
      else if (rd && addr == 4) nhold = m_cmpb / 256;
      if (wr && addr == 2) m_cmpa = m_hold * 256 + wdata;
      if (wr && addr == 4) m_cmpb = m_hold * 256 + wdata;
      if ((m_ctrl / 16) % 2 == 1 && (ma || frc % 2 == 1)) m_wa = 1 - m_wa;
      if ((m_ctrl / 32) % 2 == 1 && (mb || frc / 2 == 1)) m_wb = 1 - m_wb;
      m_flags = (m_flags & ~clr & 7) | ma | (mb * 2) | (wp * 4);
      if (wr && addr == 6) m_ctrl = wdata % 64;
      m_cnt  = ncnt;
      m_hold = nhold;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 per-cycle rdata", 16'(rdata), 16'(model_rd(int'(addr))));
      chk("R8 per-cycle wave_a", 16'(wv_a), 16'(m_wa));
      chk("R8 per-cycle wave_b", 16'(wv_b), 16'(m_wb));
      chk("R11 per-cycle irq_cmp_a", 16'(irq_a), 16'(m_flags % 2 & (m_ctrl / 2) % 2));
      chk("R11 per-cycle irq_cmp_b", 16'(irq_b), 16'((m_flags / 2) % 2 & (m_ctrl / 4) % 2));
      chk("R11 per-cycle irq_ovf", 16'(irq_o), 16'((m_flags / 4) % 2 & (m_ctrl / 8) % 2));
    end
  end

  task automatic wr8(input logic [3:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2;
    wr = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] lo_a, input logic [15:0] v);
    wr8(lo_a + 4'd1, v[15:8]);
    wr8(lo_a, v[7:0]);
  endtask

  task automatic rchk(input logic [3:0] a, input logic [7:0] exp, input string tag);
    rd = 1'b1; addr = a;
    @(negedge clk);
    chk(tag, 16'(rdata), 16'(exp));
    @(posedge clk); #2;
    rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(posedge clk);
    #2;
    tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog for all requirements: actual hang, expected end of stimulus");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 wave_a", 16'(wv_a), 16'h0);
    chk("R1 wave_b", 16'(wv_b), 16'h0);
    chk("R1 irqs", 16'({irq_a, irq_b, irq_o}), 16'h0);
    @(posedge clk); #2;
    for (int a = 0; a < 9; a++) rchk(4'(a), 8'h00, "R1 reset readback");

    // R2 shared holding byte and commit on low write
    wr8(4'd3, 8'hAB);
    wr8(4'd4, 8'h11);
    rchk(4'd4, 8'h11, "R2 cmpB low after cross-register commit");
    rchk(4'd5, 8'hAB, "R2 cmpB high from shared holding byte");
    rchk(4'd2, 8'h00, "R2 cmpA low untouched");
    rchk(4'd3, 8'h00, "R2 cmpA high untouched");
    wr8(4'd5, 8'h77);
    rchk(4'd4, 8'h11, "R2 high-only write leaves target");
    rchk(4'd5, 8'hAB, "R3 high read after low read");

    // R3 stale high byte while counter moves
    wr16(4'd0, 16'h12FF);
    rchk(4'd0, 8'hFF, "R3 counter low");
    ticks(1);
    rchk(4'd1, 8'h12, "R3 latched high survives carry");
    rchk(4'd0, 8'h00, "R3 counter low after step");
    rchk(4'd1, 8'h13, "R3 counter high after step");

    // R4 wrap and overflow
    wr8(4'd6, 8'h08);
    wr16(4'd0, 16'hFFFE);
    ticks(2);
    @(negedge clk);
    chk("R11 irq_ovf raised", 16'(irq_o), 16'h1);
    @(posedge clk); #2;
    rchk(4'd8, 8'h04, "R4 overflow flag");
    rchk(4'd0, 8'h00, "R4 wrapped to zero");

    // R10 write-one-to-clear
    wr8(4'd8, 8'h04);
    rchk(4'd8, 8'h00, "R10 overflow cleared");

    // R6 R8 R11 matches in normal mode
    wr16(4'd2, 16'h0010);
    wr16(4'd4, 16'h0020);
    wr8(4'd6, 8'h36);
    wr16(4'd0, 16'h000E);
    ticks(3);
    @(negedge clk);
    chk("R8 wave_a toggled on match", 16'(wv_a), 16'h1);
    chk("R11 irq_cmp_a", 16'(irq_a), 16'h1);
    chk("R11 irq_cmp_b idle", 16'(irq_b), 16'h0);
    @(posedge clk); #2;
    rchk(4'd8, 8'h01, "R6 flag A");

    // R7 load suppresses next-tick match
    wr16(4'd0, 16'h0020);
    ticks(1);
    rchk(4'd8, 8'h01, "R7 no flag B on masked tick");
    rchk(4'd0, 8'h21, "R7 masked tick still increments");
    @(negedge clk);
    chk("R7 wave_b unchanged", 16'(wv_b), 16'h0);
    @(posedge clk); #2;
    wr16(4'd0, 16'h001F);
    ticks(2);
    rchk(4'd8, 8'h03, "R6 flag B on unmasked tick");
    @(negedge clk);
    chk("R8 wave_b toggled", 16'(wv_b), 16'h1);
    @(posedge clk); #2;

    // R5 clear-on-compare-A
    wr8(4'd8, 8'h07);
    wr8(4'd6, 8'h37);
    wr16(4'd0, 16'h000E);
    ticks(3);
    rchk(4'd0, 8'h00, "R5 counter cleared at compare A");
    rchk(4'd8, 8'h01, "R5 match without overflow");
    @(negedge clk);
    chk("R8 wave_a toggled back", 16'(wv_a), 16'h0);
    @(posedge clk); #2;
    wr8(4'd8, 8'h01);
    wr16(4'd0, 16'h0010);
    ticks(1);
    rchk(4'd0, 8'h00, "R5 clear on masked tick");
    rchk(4'd8, 8'h00, "R7 masked tick sets no flag");

    // R9 force strobes
    wr16(4'd0, 16'h0010);
    wr8(4'd7, 8'h01);
    @(negedge clk);
    chk("R9 force toggles wave_a", 16'(wv_a), 16'h1);
    chk("R9 force raises no irq", 16'(irq_a), 16'h0);
    @(posedge clk); #2;
    rchk(4'd8, 8'h00, "R9 force sets no flag");
    rchk(4'd0, 8'h10, "R9 force keeps counter");
    rchk(4'd7, 8'h00, "R9 force reads zero");
    wr8(4'd6, 8'h17);
    wr8(4'd7, 8'h02);
    @(negedge clk);
    chk("R9 force ignored without toggle enable", 16'(wv_b), 16'h1);
    @(posedge clk); #2;

    // R10 set wins over clear
    wr16(4'd0, 16'h000F);
    ticks(1);
    tick = 1'b1; wr = 1'b1; addr = 4'd8; wdata = 8'h01;
    @(posedge clk); #2;
    tick = 1'b0; wr = 1'b0;
    rchk(4'd8, 8'h01, "R10 set wins over clear");

    // R4 long free run through a natural wrap
    wr8(4'd8, 8'h07);
    wr8(4'd6, 8'h3E);
    wr16(4'd2, 16'h0100);
    wr16(4'd4, 16'h8000);
    wr16(4'd0, 16'h0000);
    tick = 1'b1;
    for (int k = 0; k < 14; k++) begin
      repeat (5000) @(posedge clk);
      #2;
      wr8(4'd8, 8'h03);
    end
    tick = 1'b0;
    rchk(4'd8, 8'h04, "R4 overflow after natural wrap");

    finish_run();
  end
endmodule